// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a system watchdog with a small register port. Software programs a 16-bit time count together with mode bits in a control register, and it may do so only once after power-on reset. While enabled, a 16-bit counter runs down from that time count. A tick is either every system clock or one clock in every 2^PRESCALE_LOG2 clocks. To keep the watchdog alive, software writes an arming key and then a firing key to the service register. If the counter runs out first, the block raises a held interrupt or a one-cycle reset request, depending on the programmed mode. In reset mode it also sets a sticky cause flag that survives until software clears it by writing 1.

The register port is a single-cycle select/write strobe with a combinational read path. A freeze bit makes the counter respect a debug-halt input. The asynchronous active-low reset is released through a two-stage synchronizer. For this reason, the block's state stays in its reset values for two clocks after `rst_n` rises.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, every register reads 0 at every address, and `wdt_irq` and `wdt_rst_req` are low.
- R2: The first write to address 0 after reset is accepted, and its fields read back unchanged: time count in bits 31:16, freeze in bit 3, enable in bit 2, reset-select in bit 1 (1 = reset, 0 = interrupt), prescale in bit 0. That write also loads the counter with the time count. Every later write to address 0 is ignored, so a refused enable reads back as 0 in bit 2.
- R3: Address 1 reads the counter in bits 15:0, with 0 in bits 31:16. When enable is 0 the counter holds its value. When enable is 1 it drops by one per tick and stops at 0.
- R4: With prescale set, a tick occurs once every 2^PRESCALE_LOG2 clocks, counted from the last load or reload. With prescale clear, every clock is a tick.
- R5: Writing 0x556C and then 0xAA39 to bits 15:0 of address 2 reloads the counter from the time count and clears the prescaler. A repeated 0x556C keeps the sequence armed.
- R6: A 0xAA39 without a directly preceding 0x556C does not reload the counter. Neither does any other value. Such a write cancels an armed sequence.
- R7: In interrupt mode, a counter step from 1 to 0 raises `wdt_irq`, which stays high until the next valid service. The counter stays at 0.
- R8: In reset mode, a counter step from 1 to 0 pulses `wdt_rst_req` high for exactly one clock, sets bit 0 of address 3, and leaves `wdt_irq` low.
- R9: Bit 0 of address 3 stays set until a write to address 3 with bit 0 = 1. Writing 0 leaves it set.
- R10: While freeze is set and `dbg_halt` is high, both the counter and the prescaler hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_halt | input | 1 | Debug halt; stops counting when freeze is set |
| reg_sel | input | 1 | Register access select |
| reg_wr | input | 1 | Write strobe, qualified by reg_sel |
| reg_addr | input | 2 | Word address: 0 control, 1 count, 2 service, 3 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| wdt_irq | output | 1 | Held expiry interrupt |
| wdt_rst_req | output | 1 | One-clock expiry reset request |

## Verification
A wrongly tracked key state shows up within one service write as a count that is reloaded when it should not be, or not reloaded when it should, and the next count read exposes it. A prescaler that drifts or ignores the halt moves the counter step by one or more clocks, so the bench samples the count on the clocks on either side of the expected tick. A broken lock or sticky flag appears on the first read-back after the illegal write.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned KEY_W  = 16;
  localparam int unsigned TC_LSB = DATA_W - CNT_W;

  localparam logic [ADDR_W-1:0] A_CTL = 2'd0;
  localparam logic [ADDR_W-1:0] A_CNT = 2'd1;
  localparam logic [ADDR_W-1:0] A_SVC = 2'd2;
  localparam logic [ADDR_W-1:0] A_STS = 2'd3;

  localparam int unsigned B_FRZ   = 3;
  localparam int unsigned B_EN    = 2;
  localparam int unsigned B_RSEL  = 1;
  localparam int unsigned B_PSE   = 0;
  localparam int unsigned B_CAUSE = 0;

  localparam logic [KEY_W-1:0] KEY_ARM  = 16'h556C;
  localparam logic [KEY_W-1:0] KEY_FIRE = 16'hAA39;

  typedef struct packed {
    logic [CNT_W-1:0] tc;
    logic             frz;
    logic             en;
    logic             rsel;
    logic             pse;
  } wdt_ctl_t;

  typedef enum logic {SVC_IDLE = 1'b0, SVC_ARMED = 1'b1} svc_state_e;
endpackage

// File: rtl/wdt_ctl_regs.sv
module wdt_ctl_regs
  import keyed_wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              sts_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire_rst,
  output logic              ctl_accept,
  output wdt_ctl_t          ctl,
  output logic              locked,
  output logic              cause
);
  wdt_ctl_t ctl_q, ctl_d;
  logic     locked_q, locked_d;
  logic     cause_q, cause_d;

  assign ctl_accept = ctl_wr && !locked_q;

  always_comb begin
    ctl_d    = ctl_q;
    locked_d = locked_q;
    if (ctl_accept) begin
      ctl_d.tc   = wdata[DATA_W-1:TC_LSB];
      ctl_d.frz  = wdata[B_FRZ];
      ctl_d.en   = wdata[B_EN];
      ctl_d.rsel = wdata[B_RSEL];
      ctl_d.pse  = wdata[B_PSE];
      locked_d   = 1'b1;
    end
  end

  always_comb begin
    cause_d = cause_q;
    if (sts_wr && wdata[B_CAUSE]) cause_d = 1'b0;
    if (expire_rst)               cause_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      locked_q <= 1'b0;
    end else if (ctl_accept) begin
      ctl_q    <= ctl_d;
      locked_q <= locked_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= 1'b0;
    else        cause_q <= cause_d;
  end

  assign ctl    = ctl_q;
  assign locked = locked_q;
  assign cause  = cause_q;
endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
  import keyed_wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_wr,
  input  logic [KEY_W-1:0] svc_data,
  output logic             reload
);
  svc_state_e st_q, st_d;
  logic       is_arm, is_fire;

  assign is_arm  = (svc_data == KEY_ARM);
  assign is_fire = (svc_data == KEY_FIRE);

  always_comb begin
    st_d   = st_q;
    reload = 1'b0;
    if (svc_wr) begin
      if (is_arm) begin
        st_d = SVC_ARMED;
      end else begin
        st_d = SVC_IDLE;
        if (is_fire && st_q == SVC_ARMED) reload = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= SVC_IDLE;
    else if (svc_wr) st_q <= st_d;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W         = 16,
  parameter int unsigned PRESCALE_LOG2 = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             en,
  input  logic             pse,
  input  logic             hold,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run, wrap, tick, pre_clr, pre_adv;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign run     = en && !hold;
  assign pre_clr = load || reload;
  assign pre_adv = run && pse;

  generate
    if (PRESCALE_LOG2 > 0) begin : g_pre
      logic [PRESCALE_LOG2-1:0] pre_q, pre_d;
      always_comb begin
        pre_d = pre_q;
        if (pre_clr)      pre_d = '0;
        else if (pre_adv) pre_d = pre_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  pre_q <= '0;
        else if (pre_clr || pre_adv) pre_q <= pre_d;
      end
      assign wrap = &pre_q;
    end else begin : g_nopre
      assign wrap = 1'b1;
    end
  endgenerate

  assign tick = pse ? wrap : 1'b1;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (reload) begin
      cnt_d = reload_val;
    end else if (run && tick && cnt_q != '0) begin
      cnt_d  = cnt_q - ONE;
      expire = (cnt_q == ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import keyed_wdt_pkg::*;
#(
  parameter int unsigned PRESCALE_LOG2 = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_halt,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wdt_irq,
  output logic              wdt_rst_req
);
  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  logic             wr_any, ctl_wr, svc_wr, sts_wr;
  logic             ctl_accept, ctl_locked, cause, svc_reload;
  logic             expire, hold;
  wdt_ctl_t         ctl;
  logic [CNT_W-1:0] cnt;
  logic             irq_q, irq_d, rreq_q, rreq_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign wr_any = reg_sel && reg_wr;
  assign ctl_wr = wr_any && (reg_addr == A_CTL);
  assign svc_wr = wr_any && (reg_addr == A_SVC);
  assign sts_wr = wr_any && (reg_addr == A_STS);
  assign hold   = ctl.frz && dbg_halt;

  wdt_ctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .ctl_wr     (ctl_wr),
    .sts_wr     (sts_wr),
    .wdata      (reg_wdata),
    .expire_rst (expire && ctl.rsel),
    .ctl_accept (ctl_accept),
    .ctl        (ctl),
    .locked     (ctl_locked),
    .cause      (cause)
  );

  wdt_key_fsm u_keys (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .svc_wr   (svc_wr),
    .svc_data (reg_wdata[KEY_W-1:0]),
    .reload   (svc_reload)
  );

  wdt_countdown #(
    .CNT_W         (CNT_W),
    .PRESCALE_LOG2 (PRESCALE_LOG2)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .load       (ctl_accept),
    .load_val   (reg_wdata[DATA_W-1:TC_LSB]),
    .reload     (svc_reload),
    .reload_val (ctl.tc),
    .en         (ctl.en),
    .pse        (ctl.pse),
    .hold       (hold),
    .cnt        (cnt),
    .expire     (expire)
  );

  always_comb begin
    irq_d = irq_q;
    if (svc_reload)               irq_d = 1'b0;
    else if (expire && !ctl.rsel) irq_d = 1'b1;
    rreq_d = expire && ctl.rsel;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      irq_q  <= 1'b0;
      rreq_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      rreq_q <= rreq_d;
    end
  end

  assign wdt_irq     = irq_q;
  assign wdt_rst_req = rreq_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTL: begin
        reg_rdata[DATA_W-1:TC_LSB] = ctl.tc;
        reg_rdata[B_FRZ]           = ctl.frz;
        reg_rdata[B_EN]            = ctl.en;
        reg_rdata[B_RSEL]          = ctl.rsel;
        reg_rdata[B_PSE]           = ctl.pse;
      end
      A_CNT:   reg_rdata[CNT_W-1:0] = cnt;
      A_STS:   reg_rdata[B_CAUSE]   = cause;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk
  import keyed_wdt_pkg::*;
(
  input logic              clk,
  input logic              rst_s_n,
  input logic              dbg_halt,
  input logic              sts_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              wdt_irq,
  input logic              wdt_rst_req,
  input wdt_ctl_t          ctl,
  input logic              ctl_locked,
  input logic [CNT_W-1:0]  cnt,
  input logic              svc_reload,
  input logic              cause
);
  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    wdt_rst_req |=> !wdt_rst_req);

  // R8
  rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    wdt_rst_req |-> (cause && !wdt_irq));

  // R7
  irq_zero_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(wdt_irq) |-> (cnt == '0));

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wdt_irq && !svc_reload) |=> wdt_irq);

  // R5
  reload_val_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    svc_reload |=> (cnt == $past(ctl.tc)));

  // R2
  ctl_lock_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ctl_locked |=> (ctl_locked && $stable(ctl)));

  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ctl_locked && ctl.frz && dbg_halt && !svc_reload) |=> $stable(cnt));

  // R9
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cause && !(sts_wr && reg_wdata[B_CAUSE])) |=> cause);
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
  .clk         (clk),
  .rst_s_n     (rst_s_n),
  .dbg_halt    (dbg_halt),
  .sts_wr      (sts_wr),
  .reg_wdata   (reg_wdata),
  .wdt_irq     (wdt_irq),
  .wdt_rst_req (wdt_rst_req),
  .ctl         (ctl),
  .ctl_locked  (ctl_locked),
  .cnt         (cnt),
  .svc_reload  (svc_reload),
  .cause       (cause)
);

// File: tb/keyed_wdt_tb.sv
`timescale 1ns/1ps
module keyed_wdt_tb;
  localparam int PL = 3;
  localparam logic [15:0] K_ARM  = 16'h556C;
  localparam logic [15:0] K_FIRE = 16'hAA39;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        wdt_irq, wdt_rst_req;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  int          m_cnt;
  bit          m_arm;
  bit          m_irq;
  logic [15:0] m_tc;

  always #2.5 clk = ~clk;

  keyed_wdt #(.PRESCALE_LOG2(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
  );

  function automatic logic [31:0] mk_ctl(logic [15:0] tc, bit frz, bit en, bit rsel, bit pse);
    return {tc, 12'd0, frz, en, rsel, pse};
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 32'd0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
  endtask

  // model of one unprescaled cycle with no service write
  function automatic void m_step();
    if (m_cnt != 0) begin
      if (m_cnt == 1) m_irq = 1'b1;
      m_cnt--;
    end
  endfunction

  task automatic svc_step(logic [15:0] v, string req);
    logic [31:0] d;
    bit rel;
    wr(2'd2, {16'd0, v});
    rel   = m_arm && (v == K_FIRE);
    m_arm = (v == K_ARM);
    if (rel) begin
      m_cnt = m_tc;
      m_irq = 1'b0;
    end else begin
      m_step();
    end
    rd(2'd1, d);
    check(req, d, 32'(m_cnt));
    check({req, " irq"}, {31'd0, wdt_irq}, {31'd0, m_irq});
  endtask

  initial begin
    logic [31:0] d;
    logic [15:0] v;
    int r;
    void'($urandom(32'd12345));

    // ---------- R1 reset state ----------
    do_reset();
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check("R1 reg", d, 32'd0);
    end
    check("R1 irq", {31'd0, wdt_irq}, 32'd0);
    check("R1 rst_req", {31'd0, wdt_rst_req}, 32'd0);

    // ---------- Scenario A: interrupt mode, no prescale ----------
    m_tc = 16'd20;
    wr(2'd0, mk_ctl(m_tc, 1'b0, 1'b1, 1'b0, 1'b0));
    m_cnt = 20; m_arm = 1'b0; m_irq = 1'b0;
    rd(2'd0, d);
    check("R2 ctl readback", d, mk_ctl(m_tc, 1'b0, 1'b1, 1'b0, 1'b0));
    rd(2'd1, d);
    check("R2 load", d, 32'd20);
    idle(5);
    for (int i = 0; i < 5; i++) m_step();
    rd(2'd1, d);
    check("R3 countdown", d, 32'(m_cnt));
    wr(2'd0, 32'd0);
    m_step();
    rd(2'd0, d);
    check("R2 second write ignored", d, mk_ctl(m_tc, 1'b0, 1'b1, 1'b0, 1'b0));
    rd(2'd1, d);
    check("R2 still counting", d, 32'(m_cnt));

    svc_step(K_ARM, "R5 arm");
    svc_step(K_FIRE, "R5 fire");
    svc_step(K_FIRE, "R6 lone fire");
    svc_step(K_ARM, "R5 arm1");
    svc_step(K_ARM, "R5 arm2");
    svc_step(K_FIRE, "R5 double arm");
    svc_step(K_ARM, "R6 arm");
    svc_step(16'h1234, "R6 junk");
    svc_step(K_FIRE, "R6 fire after junk");

    for (int i = 0; i < 60; i++) begin
      r = int'($urandom % 4);
      if (r == 0) v = K_ARM;
      else if (r == 1) v = K_FIRE;
      else begin
        v = 16'($urandom);
        if (v == K_ARM || v == K_FIRE) v = 16'h0F0F;
      end
      svc_step(v, "R5/R6 random");
    end

    svc_step(K_ARM, "R5 arm");
    svc_step(K_FIRE, "R5 fire");
    idle(25);
    for (int i = 0; i < 25; i++) m_step();
    rd(2'd1, d);
    check("R7 count at zero", d, 32'd0);
    check("R7 irq held", {31'd0, wdt_irq}, 32'd1);
    check("R7 no rst_req", {31'd0, wdt_rst_req}, 32'd0);
    rd(2'd3, d);
    check("R7 no cause", d, 32'd0);
    svc_step(K_ARM, "R7 arm");
    svc_step(K_FIRE, "R7 service clears irq");

    // ---------- Scenario B: reset mode, prescale, freeze ----------
    do_reset();
    wr(2'd0, mk_ctl(16'd3, 1'b1, 1'b1, 1'b1, 1'b1));
    dbg_halt = 1'b1;
    idle(40);
    rd(2'd1, d);
    check("R10 halted count", d, 32'd3);
    dbg_halt = 1'b0;
    idle(4);
    dbg_halt = 1'b1;
    idle(20);
    rd(2'd1, d);
    check("R10 prescaler hold", d, 32'd3);
    dbg_halt = 1'b0;
    idle(3);
    rd(2'd1, d);
    check("R4 before tick", d, 32'd3);
    idle(1);
    rd(2'd1, d);
    check("R4 first tick", d, 32'd2);
    idle(15);
    rd(2'd1, d);
    check("R4 third tick pending", d, 32'd1);
    check("R8 rst_req low", {31'd0, wdt_rst_req}, 32'd0);
    idle(1);
    check("R8 rst_req pulse", {31'd0, wdt_rst_req}, 32'd1);
    check("R8 irq low", {31'd0, wdt_irq}, 32'd0);
    rd(2'd1, d);
    check("R8 count zero", d, 32'd0);
    rd(2'd3, d);
    check("R8 cause set", d, 32'd1);
    idle(1);
    check("R8 pulse one cycle", {31'd0, wdt_rst_req}, 32'd0);
    wr(2'd3, 32'd0);
    rd(2'd3, d);
    check("R9 write 0 keeps", d, 32'd1);
    wr(2'd3, 32'd1);
    rd(2'd3, d);
    check("R9 write 1 clears", d, 32'd0);

    // ---------- Scenario C: disabled, enable refused ----------
    do_reset();
    wr(2'd0, mk_ctl(16'd5, 1'b0, 1'b0, 1'b0, 1'b0));
    idle(20);
    rd(2'd1, d);
    check("R3 disabled holds", d, 32'd5);
    wr(2'd0, mk_ctl(16'd5, 1'b0, 1'b1, 1'b0, 1'b0));
    rd(2'd0, d);
    check("R2 enable refused", d, mk_ctl(16'd5, 1'b0, 1'b0, 1'b0, 1'b0));
    idle(10);
    rd(2'd1, d);
    check("R3 still held", d, 32'd5);
    check("R7 no irq when disabled", {31'd0, wdt_irq}, 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule